// File: doc/BRIEF.md
# Programmable Periodic Countdown Timer Channel

This block is one timer channel with a small register port. Software writes a control word. The word holds a run flag, a repeat flag and a period of up to 28 bits. The channel then counts down once per pulse of a tick input, and a separate source register picks which tick input is used. When the count runs out, the channel raises a one-cycle expiry pulse and sets a sticky pending flag. In repeat mode it reloads the period and carries on. Otherwise it stops.

Other blocks can use the expiry pulse directly, for example a watchdog that counts expirations. The interrupt line is the pending flag masked by the last written run flag. Software clears the pending flag by writing a one to its bit in the status word. Tick generation and interrupt routing are outside this block.

Top module: `periodic_timer`

## Requirements
- R1: After synchronous reset, `expiry_o` and `irq_o` are 0 and the control word (offset 0x0), status word (offset 0x4) and source word (offset 0x8) all read 0.
- R2: A write to offset 0x0 with bit 31 set loads the period from bits 27:0 and starts counting. Each selected tick pulse sampled at a clock edge lowers the count by one. The tick that meets a count of 1 or 0 is the expiring tick, so a period of P expires after P ticks and a period of 0 behaves like 1. `expiry_o` is high for exactly the one cycle after the edge that sampled the expiring tick.
- R3: With bit 30 of the control word set (repeat mode), an expiry reloads the period and counting continues without a new write.
- R4: With bit 30 clear (one-shot mode), an expiry stops the channel, and bit 31 of the control word then reads 0.
- R5: Status bit 30 is set on the same edge as each expiry. Writing 1 to bit 30 at offset 0x4 clears it, and writing 0 there leaves it unchanged. If an expiry and a clear land on the same edge, the bit stays set.
- R6: `irq_o` equals status bit 30 ANDed with bit 31 of the last word written to offset 0x0. It stays high after a one-shot expiry until it is cleared.
- R7: Writing 0 to offset 0x0 stops the channel. No further expiry occurs until the next write with bit 31 set.
- R8: A control write while the channel is running restarts the count from the new period. When a control write and a tick fall on the same edge, the write wins.
- R9: The source word at offset 0x8 (bits 1:0 with three tick inputs) selects `tick_i[n]`. Value 0 picks the microsecond tick `tick_i[0]`. Values of 3 or more select no tick, and the count then holds. A new source takes effect from the edge after it is written.
- R10: A read request (`rd_en`) at one edge returns the addressed word on `rdata` from the next cycle. Control bits 29:28 read 0, and any offset other than 0x0, 0x4 and 0x8 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | NUM_TICKS | Tick pulses; bit 0 is the microsecond tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| expiry_o | output | 1 | One-cycle pulse per expiry |
| irq_o | output | 1 | Pending flag masked by the written run flag |

## Verification
A wrong count shows at the ports as an `expiry_o` pulse that comes a cycle early or late relative to the tick stream. That makes every off-by-one in the load or decrement visible at the first expiry after a write. A repeat or run flag that is left in the wrong state shows as a missing or extra pulse at the next expiration, and the control read-back shows it at once. A pending flag that is wrong shows on `irq_o` in the very next cycle. So a reference model compared on every edge localises a fault to within one tick period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W       = 32;
  localparam int OFS_CTRL     = 0;
  localparam int OFS_STAT     = 4;
  localparam int OFS_SRC      = 8;
  localparam int BIT_RUN      = 31;
  localparam int BIT_REPEAT   = 30;
  localparam int BIT_PENDING  = 30;
endpackage

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux #(
  parameter int NUM_TICKS = 3,
  parameter int SEL_W     = 2
) (
  input  logic [NUM_TICKS-1:0] tick_i,
  input  logic [SEL_W-1:0]     sel,
  output logic                 tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TICKS; i++) begin
      if (sel == SEL_W'(i)) tick = tick_i[i];
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                load_run,
  input  logic                load_repeat,
  input  logic [PERIOD_W-1:0] load_period,
  input  logic                tick,
  output logic                running,
  output logic                repeat_mode,
  output logic [PERIOD_W-1:0] period,
  output logic                hit,
  output logic                expire_q
);
  logic [PERIOD_W-1:0] count;

  assign hit = !load && running && tick && (count <= PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      repeat_mode <= 1'b0;
      period      <= '0;
      count       <= '0;
      expire_q    <= 1'b0;
    end else begin
      expire_q <= hit;
      if (load) begin
        running     <= load_run;
        repeat_mode <= load_repeat;
        period      <= load_period;
        count       <= load_period;
      end else if (running && tick) begin
        if (hit) begin
          if (repeat_mode) count <= period;
          else begin
            running <= 1'b0;
            count   <= '0;
          end
        end else begin
          count <= count - PERIOD_W'(1);
        end
      end
    end
  end

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_q && !repeat_mode) |-> !running);
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_q && repeat_mode) |-> (count == period && running));
  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_period) && running == $past(load_run) && !expire_q));
  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !load) |=> ($stable(count) && !expire_q));
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)      pending <= 1'b0;
    else if (set) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> pending);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !pending);
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer #(
  parameter int NUM_TICKS = 3,
  parameter int PERIOD_W  = 28,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TICKS-1:0] tick_i,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 expiry_o,
  output logic                 irq_o
);
  import tmr_pkg::*;

  localparam int SEL_W = $clog2(NUM_TICKS + 1);

  logic                wr_ctrl, wr_stat, wr_src;
  logic [SEL_W-1:0]    src_q;
  logic                irq_en_q;
  logic                tick_sel;
  logic                running, repeat_mode, hit, pending;
  logic [PERIOD_W-1:0] period;
  logic [DATA_W-1:0]   rd_mux;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign wr_src  = wr_en && (addr == ADDR_W'(OFS_SRC));

  tmr_tick_mux #(.NUM_TICKS(NUM_TICKS), .SEL_W(SEL_W)) u_mux (
    .tick_i (tick_i),
    .sel    (src_q),
    .tick   (tick_sel)
  );

  tmr_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load        (wr_ctrl),
    .load_run    (wdata[BIT_RUN]),
    .load_repeat (wdata[BIT_REPEAT]),
    .load_period (wdata[PERIOD_W-1:0]),
    .tick        (tick_sel),
    .running     (running),
    .repeat_mode (repeat_mode),
    .period      (period),
    .hit         (hit),
    .expire_q    (expiry_o)
  );

  tmr_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .set     (hit),
    .clr     (wr_stat && wdata[BIT_PENDING]),
    .pending (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_src)  src_q    <= wdata[SEL_W-1:0];
      if (wr_ctrl) irq_en_q <= wdata[BIT_RUN];
    end
  end

  assign irq_o = pending && irq_en_q;

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_mux[BIT_RUN]        = running;
      rd_mux[BIT_REPEAT]     = repeat_mode;
      rd_mux[PERIOD_W-1:0]   = period;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rd_mux[BIT_PENDING]    = pending;
    end else if (addr == ADDR_W'(OFS_SRC)) begin
      rd_mux[SEL_W-1:0]      = src_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (expiry_o && irq_en_q) |-> irq_o);
  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (!expiry_o && !irq_o && rdata == '0));
endmodule

// File: tb/tb_periodic_timer.sv
module tb_periodic_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  tick_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        expiry_o, irq_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_run, m_rep, m_pend, m_ien, m_exp;
  int m_period, m_cnt, m_src;

  always #2 clk = ~clk;

  periodic_timer dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .expiry_o(expiry_o), .irq_o(irq_o)
  );

  // tick patterns: 0 every third cycle, 1 every cycle, 2 every fifth
  initial forever begin
    @(negedge clk);
    cyc++;
    tick_i[0] = (cyc % 3 == 0);
    tick_i[1] = 1'b1;
    tick_i[2] = (cyc % 5 == 0);
  end

  always @(posedge clk) begin
    bit t, hit;
    if (rst) begin
      m_run = 0; m_rep = 0; m_pend = 0; m_ien = 0; m_exp = 0;
      m_period = 0; m_cnt = 0; m_src = 0;
    end else begin
      t = (m_src < 3) ? tick_i[m_src] : 1'b0;
      hit = 0;
      if (wr_en && addr == 4'h0) begin
        m_run = wdata[31]; m_rep = wdata[30]; m_ien = wdata[31];
        m_period = int'(wdata[27:0]); m_cnt = m_period;
      end else if (m_run && t) begin
        if (m_cnt <= 1) begin
          hit = 1;
          if (m_rep) m_cnt = m_period;
          else begin m_run = 0; m_cnt = 0; end
        end else m_cnt--;
      end
      m_exp = hit;
      if (hit) m_pend = 1;
      else if (wr_en && addr == 4'h4 && wdata[30]) m_pend = 0;
      if (wr_en && addr == 4'h8) m_src = int'(wdata[1:0]);
    end
  end

  // R2 R3 R4 R5 R6 R7 R8 R9: compare outputs every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (expiry_o !== m_exp || irq_o !== (m_pend & m_ien)) begin
        errors++;
        $display("FAIL R2/R6 cycle %0d: expiry=%b irq=%b expected expiry=%b irq=%b",
                 cyc, expiry_o, irq_o, m_exp, m_pend & m_ien);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    case (a)
      4'h0: exp = {m_run, m_rep, 2'b00, 28'(m_period)};
      4'h4: exp = {1'b0, m_pend, 30'd0};
      4'h8: exp = 32'(m_src);
      default: exp = '0;
    endcase
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%0h: got 0x%08h expected 0x%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
    // R3 repeat mode on every-cycle tick, period 5
    wr(4'h8, 32'd1);
    rd(4'h8, "R9");
    wr(4'h0, 32'hC000_0005);
    idle(20);
    rd(4'h0, "R3"); rd(4'h4, "R5");
    // R5 writing 0 leaves status, writing 1 clears
    wr(4'h4, 32'h0);
    rd(4'h4, "R5");
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, "R5");
    // R8 restart mid-run with a longer period
    idle(2);
    wr(4'h0, 32'hC000_0009);
    idle(4);
    wr(4'h0, 32'hC000_0003);
    idle(12);
    // R7 stop
    wr(4'h0, 32'h0);
    idle(15);
    rd(4'h0, "R7");
    // R4 one-shot on microsecond tick (source 0), period 4
    wr(4'h4, 32'h4000_0000);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h8000_0004);
    idle(25);
    rd(4'h0, "R4"); rd(4'h4, "R6");
    // R2 period 0 acts as 1
    wr(4'h4, 32'h4000_0000);
    wr(4'h0, 32'h8000_0000);
    idle(8);
    // R9 source 2 repeat, then an invalid source holds the count
    wr(4'h8, 32'd2);
    wr(4'h0, 32'hC000_0002);
    idle(30);
    wr(4'h8, 32'd7);
    rd(4'h8, "R9");
    idle(20);
    // R5 set wins over coincident clear: period 1 every cycle
    wr(4'h8, 32'd1);
    wr(4'h0, 32'hC000_0001);
    for (int i = 0; i < 6; i++) wr(4'h4, 32'h4000_0000);
    rd(4'h4, "R5");
    // R10 unmapped offset and reserved control bits
    wr(4'h0, 32'hF000_0010);
    rd(4'h0, "R10");
    rd(4'hC, "R10");
    rd(4'h2, "R10");
    idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule